// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the software-visible control and status store of a DMA engine with up to 64 channels. For every channel it keeps six single-bit state vectors: hardware-request enable, error-interrupt enable, interrupt-request flag, error flag, channel-done and channel-start. Software reaches each vector through a simple word-wide register bus as two 32-bit words. The upper word holds channels 63 down to 32 and the lower word holds channels 31 down to 0.

Eight byte-wide command registers change one bit of one vector at a time. Each takes a channel number as its write data. The transfer engine reports progress through three per-channel pulse inputs: interrupt, error and done. It also supplies an error detail code with every error pulse.

The first error is captured in an error status word by a two-state machine. In `ES_EMPTY` no error is held. The transition `capture` moves it to `ES_HELD` on any error pulse, and the transition `release` returns it to `ES_EMPTY` when software clears the word. A single level interrupt output summarises the pending flags. A parameter `NCH` selects 64 channels or a reduced variant of up to 32 channels, in which every upper word reads as zero.

Top module: `dmacsr_regs`

## Requirements
- R1: After reset every channel vector, the control word and the error status word read zero, and `irq` is low.
- R2: A read strobe at word address A is answered in the next cycle with `bus_rvalid` high and `bus_rdata` holding the register. The address map is: 0 control, 1 error status, 2/3 request enable, 4/5 error-interrupt enable, 6/7 interrupt flags, 8/9 error flags, 10/11 done, 12/13 start. In each pair the even address is the upper word and the odd address is the lower word.
- R3: Writing a channel number in `bus_wdata[7:0]` to a command address changes exactly that channel's bit. The commands are: 16 set request enable, 17 clear request enable, 18 set error-interrupt enable, 19 clear error-interrupt enable, 20 clear interrupt flag, 21 clear error flag, 22 set start, 23 clear done.
- R4: A command write whose channel number is NCH or above changes no state.
- R5: A word write to a request-enable or error-interrupt-enable word loads it. In a word write to an interrupt-flag or error-flag word, each one bit clears the matching flag and each zero bit leaves it unchanged.
- R6: An interrupt or error pulse sets that channel's flag in the next cycle. When a clear from software falls in the same cycle as the pulse, the flag is still set.
- R7: The error status word is laid out as follows: bit 31 valid, bit 15 group priority error, bit 14 channel priority error, bits 13:8 channel number, bits 7:0 error detail. The detail bits are 0 destination bus, 1 source bus, 2 scatter/gather config, 3 byte-count/iteration config, 4 destination offset, 5 destination address, 6 source offset and 7 source address. The first error pulse captures the lowest pulsing channel with the present detail. Later errors leave the word unchanged until a write to address 1 with bit 31 set empties it.
- R8: `irq` is high exactly when any interrupt flag is set, or any error flag is set whose error-interrupt enable is also set.
- R9: The control word keeps only bits 31 (group/channel enable), 3 (round-robin group arbitration) and 2 (round-robin channel arbitration). All other bits read zero.
- R10: A done pulse sets the channel's done bit and clears its start bit. A set-start command falling in the same cycle as a done pulse still leaves the start bit set.
- R11: With NCH=16 the upper words read zero, and commands for channels 16 and above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| int_pulse | input | NCH | Per-channel interrupt events |
| err_pulse | input | NCH | Per-channel error events |
| done_pulse | input | NCH | Per-channel completion events |
| err_detail | input | 8 | Error cause bits accompanying err_pulse |
| err_prio | input | 2 | Bit 1 group, bit 0 channel priority error |
| req_en | output | NCH | Hardware-request enable vector |
| chan_start | output | NCH | Channel start vector |
| irq | output | 1 | Summary interrupt |

## Verification
The assertions assume that no more than one bus access happens per cycle. This matters because the request-enable check reads a command write as the only thing that can change that vector. They also assume that interrupt pulses stay short, so that a pulse followed by the interrupt going high is meaningful. The stimulus never raises `bus_wr` and `bus_rd` together. Every event is one cycle wide, and the only deliberate overlaps are the set-versus-clear collisions, which are there to exercise precedence.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

    localparam int MAXCH  = 64;
    localparam int DW     = 32;
    localparam int NBANK  = 6;
    localparam int NCMD   = 8;

    // word addresses
    localparam int A_CTRL  = 0;
    localparam int A_ESTAT = 1;
    localparam int A_BANK0 = 2;
    localparam int A_CMD0  = 16;

    localparam logic [31:0] CTRL_MASK = 32'h8000_000C;

    typedef enum logic [2:0] {
        BK_REQ   = 3'd0,
        BK_EIE   = 3'd1,
        BK_IRQ   = 3'd2,
        BK_ERR   = 3'd3,
        BK_DONE  = 3'd4,
        BK_START = 3'd5
    } bank_e;

    typedef enum logic [2:0] {
        C_SET_REQ   = 3'd0,
        C_CLR_REQ   = 3'd1,
        C_SET_EIE   = 3'd2,
        C_CLR_EIE   = 3'd3,
        C_CLR_IRQ   = 3'd4,
        C_CLR_ERR   = 3'd5,
        C_SET_START = 3'd6,
        C_CLR_DONE  = 3'd7
    } cmd_e;

    typedef enum logic {
        ES_EMPTY = 1'b0,
        ES_HELD  = 1'b1
    } es_state_e;

    function automatic logic [5:0] first_set(input logic [MAXCH-1:0] v);
        logic [5:0] r;
        r = '0;
        for (int i = MAXCH - 1; i >= 0; i--) begin
            if (v[i]) r = i[5:0];
        end
        return r;
    endfunction

    function automatic logic [MAXCH-1:0] place_words(input logic hi, input logic lo,
                                                     input logic [DW-1:0] d);
        return {(hi ? d : {DW{1'b0}}), (lo ? d : {DW{1'b0}})};
    endfunction

endpackage

// File: rtl/dmacsr_cmd_decode.sv
module dmacsr_cmd_decode
    import dmacsr_pkg::*;
#(
    parameter int NCH    = 64,
    parameter int ADDR_W = 5
) (
    input  logic                           wr,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [7:0]                     chan,
    output logic [NCMD-1:0][MAXCH-1:0]     cmd_oh
);
    localparam int CMD_SEL_W = $clog2(NCMD);

    logic             in_range;
    logic             cmd_hit;
    logic [MAXCH-1:0] chan_oh;

    assign in_range = (int'(chan) < NCH);
    assign cmd_hit  = wr && (int'(addr) >= A_CMD0) && (int'(addr) < A_CMD0 + NCMD);
    assign chan_oh  = in_range ? (MAXCH'(1) << chan[5:0]) : '0;

    for (genvar k = 0; k < NCMD; k++) begin : g_cmd
        assign cmd_oh[k] = (cmd_hit && (addr[CMD_SEL_W-1:0] == CMD_SEL_W'(k))) ? chan_oh : '0;
    end
endmodule

// File: rtl/dmacsr_flag_bank.sv
module dmacsr_flag_bank
    import dmacsr_pkg::*;
#(
    parameter int NCH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAXCH-1:0] set_v,
    input  logic [MAXCH-1:0] clr_v,
    output logic [MAXCH-1:0] q
);
    localparam logic [MAXCH-1:0] LIVE = (NCH >= MAXCH) ? '1 : ((MAXCH'(1) << NCH) - MAXCH'(1));

    // set has precedence over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~clr_v) | set_v) & LIVE;
    end
endmodule

// File: rtl/dmacsr_err_capture.sv
module dmacsr_err_capture
    import dmacsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAXCH-1:0] err_ev,
    input  logic [7:0]       detail,
    input  logic [1:0]       prio,
    input  logic             release_req,
    output logic [DW-1:0]    estat
);
    es_state_e state_q, state_d;
    logic      do_capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ES_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        do_capture = 1'b0;
        unique case (state_q)
            ES_EMPTY: begin
                if (|err_ev) begin
                    state_d    = ES_HELD;
                    do_capture = 1'b1;
                end
            end
            ES_HELD: begin
                if (release_req) begin
                    if (|err_ev) begin
                        do_capture = 1'b1;
                    end else begin
                        state_d = ES_EMPTY;
                    end
                end
            end
            default: state_d = ES_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            estat <= '0;
        end else if (do_capture) begin
            estat <= {1'b1, 15'd0, prio, first_set(err_ev), detail};
        end else if (state_d == ES_EMPTY) begin
            estat <= '0;
        end
    end
endmodule

// File: rtl/dmacsr_regs.sv
module dmacsr_regs
    import dmacsr_pkg::*;
#(
    parameter int NCH    = 64,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [NCH-1:0]    int_pulse,
    input  logic [NCH-1:0]    err_pulse,
    input  logic [NCH-1:0]    done_pulse,
    input  logic [7:0]        err_detail,
    input  logic [1:0]        err_prio,
    output logic [NCH-1:0]    req_en,
    output logic [NCH-1:0]    chan_start,
    output logic              irq
);
    localparam int A_BANK_LAST = A_BANK0 + 2 * NBANK - 1;

    logic [MAXCH-1:0]               int64, err64, done64;
    logic [NCMD-1:0][MAXCH-1:0]     cmd_oh;
    logic [MAXCH-1:0]               bset [NBANK];
    logic [MAXCH-1:0]               bclr [NBANK];
    logic [MAXCH-1:0]               bq   [NBANK];
    logic [NBANK-1:0]               wr_hi, wr_lo;
    logic [DW-1:0]                  ctrl_q;
    logic [DW-1:0]                  estat_w;
    logic                           estat_clr_w;
    logic [MAXCH-1:0]               req_q_w, err_q_w;
    logic [DW-1:0]                  rd_word;
    logic [ADDR_W-1:0]              bank_off;
    logic [2:0]                     bank_sel;

    assign int64  = MAXCH'(int_pulse);
    assign err64  = MAXCH'(err_pulse);
    assign done64 = MAXCH'(done_pulse);

    dmacsr_cmd_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .wr     (bus_wr),
        .addr   (bus_addr),
        .chan   (bus_wdata[7:0]),
        .cmd_oh (cmd_oh)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign wr_hi[b] = bus_wr && (int'(bus_addr) == A_BANK0 + 2 * b);
        assign wr_lo[b] = bus_wr && (int'(bus_addr) == A_BANK0 + 2 * b + 1);
        dmacsr_flag_bank #(.NCH(NCH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .set_v (bset[b]),
            .clr_v (bclr[b]),
            .q     (bq[b])
        );
    end

    always_comb begin
        bset[BK_REQ]   = cmd_oh[C_SET_REQ] | place_words(wr_hi[BK_REQ], wr_lo[BK_REQ], bus_wdata);
        bclr[BK_REQ]   = cmd_oh[C_CLR_REQ] | place_words(wr_hi[BK_REQ], wr_lo[BK_REQ], ~bus_wdata);
        bset[BK_EIE]   = cmd_oh[C_SET_EIE] | place_words(wr_hi[BK_EIE], wr_lo[BK_EIE], bus_wdata);
        bclr[BK_EIE]   = cmd_oh[C_CLR_EIE] | place_words(wr_hi[BK_EIE], wr_lo[BK_EIE], ~bus_wdata);
        bset[BK_IRQ]   = int64;
        bclr[BK_IRQ]   = cmd_oh[C_CLR_IRQ] | place_words(wr_hi[BK_IRQ], wr_lo[BK_IRQ], bus_wdata);
        bset[BK_ERR]   = err64;
        bclr[BK_ERR]   = cmd_oh[C_CLR_ERR] | place_words(wr_hi[BK_ERR], wr_lo[BK_ERR], bus_wdata);
        bset[BK_DONE]  = done64;
        bclr[BK_DONE]  = cmd_oh[C_CLR_DONE];
        bset[BK_START] = cmd_oh[C_SET_START];
        bclr[BK_START] = done64;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     ctrl_q <= '0;
        else if (bus_wr && int'(bus_addr) == A_CTRL)    ctrl_q <= bus_wdata & CTRL_MASK;
    end

    assign estat_clr_w = bus_wr && (int'(bus_addr) == A_ESTAT) && bus_wdata[31];

    dmacsr_err_capture u_ecap (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_ev      (err64),
        .detail      (err_detail),
        .prio        (err_prio),
        .release_req (estat_clr_w),
        .estat       (estat_w)
    );

    assign bank_off = bus_addr - ADDR_W'(A_BANK0);
    assign bank_sel = bank_off[3:1];

    always_comb begin
        rd_word = '0;
        if (int'(bus_addr) == A_CTRL) begin
            rd_word = ctrl_q;
        end else if (int'(bus_addr) == A_ESTAT) begin
            rd_word = estat_w;
        end else if (int'(bus_addr) >= A_BANK0 && int'(bus_addr) <= A_BANK_LAST) begin
            rd_word = bus_addr[0] ? bq[bank_sel][DW-1:0] : bq[bank_sel][MAXCH-1:DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_word;
        end
    end

    assign req_q_w    = bq[BK_REQ];
    assign err_q_w    = bq[BK_ERR];
    assign req_en     = bq[BK_REQ][NCH-1:0];
    assign chan_start = bq[BK_START][NCH-1:0];
    assign irq        = (|bq[BK_IRQ]) | (|(bq[BK_ERR] & bq[BK_EIE]));
endmodule

// File: rtl/dmacsr_regs_chk.sv
module dmacsr_regs_chk
    import dmacsr_pkg::*;
#(
    parameter int NCH    = 64,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rvalid,
    input logic [NCH-1:0]    int_pulse,
    input logic [NCH-1:0]    err_pulse,
    input logic              irq,
    input logic [DW-1:0]     estat,
    input logic              estat_clr,
    input logic [MAXCH-1:0]  req_q,
    input logic [MAXCH-1:0]  err_q
);
    logic oor_req_cmd;
    assign oor_req_cmd = bus_wr && (int'(bus_wdata[7:0]) >= NCH) &&
                         ((int'(bus_addr) == A_CMD0 + int'(C_SET_REQ)) ||
                          (int'(bus_addr) == A_CMD0 + int'(C_CLR_REQ)));

    assert_read_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    assert_no_spurious_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    assert_oor_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oor_req_cmd |=> $stable(req_q));
    assert_err_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_pulse) |=> ((err_q & MAXCH'($past(err_pulse))) == MAXCH'($past(err_pulse))));
    assert_first_error_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (estat[31] && !estat_clr) |=> $stable(estat));
    assert_irq_follows_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|int_pulse) |=> irq);
endmodule

bind dmacsr_regs dmacsr_regs_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .int_pulse  (int_pulse),
    .err_pulse  (err_pulse),
    .irq        (irq),
    .estat      (estat_w),
    .estat_clr  (estat_clr_w),
    .req_q      (req_q_w),
    .err_q      (err_q_w)
);

// File: tb/dmacsr_regs_bench.sv
module dmacsr_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_s;
    logic        rvalid, rvalid_s;
    logic [63:0] int_p = '0, err_p = '0, done_p = '0;
    logic [7:0]  detail = '0;
    logic [1:0]  prio = '0;
    logic [63:0] req_en, start_v;
    logic [15:0] req_en_s, start_s;
    logic        irq, irq_s;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [32:0] sexp_q[$];

    always #5 clk = ~clk;

    dmacsr_regs #(.NCH(64)) u_dmacsr_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
        .int_pulse(int_p), .err_pulse(err_p), .done_pulse(done_p),
        .err_detail(detail), .err_prio(prio), .req_en(req_en), .chan_start(start_v), .irq(irq));

    dmacsr_regs #(.NCH(16)) u_dmacsr_regs_small (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .bus_rvalid(rvalid_s),
        .int_pulse(int_p[15:0]), .err_pulse(err_p[15:0]), .done_pulse(done_p[15:0]),
        .err_detail(detail), .err_prio(prio), .req_en(req_en_s), .chan_start(start_s), .irq(irq_s));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rvalid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected response", rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                logic [32:0] s;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                s = sexp_q.pop_front();
                chk(rdata == e, t, rdata, e);
                if (s[32]) chk(rdata_s == s[31:0], {t, " (16ch)"}, rdata_s, s[31:0]);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag,
                      input bit sc = 1'b0, input logic [31:0] se = 32'h0);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag); sexp_q.push_back({sc, se});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ev(input logic [63:0] iv, input logic [63:0] ev_, input logic [63:0] dv);
        @(negedge clk);
        int_p = iv; err_p = ev_; done_p = dv;
        @(negedge clk);
        int_p = '0; err_p = '0; done_p = '0;
    endtask

    initial begin
        #2000000;
        chk(1'b0, "watchdog expired", 32'h0, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq == 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(5'd0, 32'h0, "R1 control after reset");
        rd(5'd1, 32'h0, "R1 error status after reset");
        rd(5'd3, 32'h0, "R1 request enable low after reset");
        // R9 control bits
        wr(5'd0, 32'hFFFF_FFFF);
        rd(5'd0, 32'h8000_000C, "R9 control keeps bits 31,3,2");
        // R3 set request commands, R11 reduced variant
        wr(5'd16, 32'd5);
        wr(5'd16, 32'd40);
        rd(5'd3, 32'h0000_0020, "R3 set request ch5", 1'b1, 32'h0000_0020);
        rd(5'd2, 32'h0000_0100, "R3 set request ch40 / R11 upper zero", 1'b1, 32'h0);
        // R4 out-of-range commands
        wr(5'd16, 32'd64);
        wr(5'd16, 32'd200);
        wr(5'd17, 32'd64);
        rd(5'd3, 32'h0000_0020, "R4 out-of-range low word");
        rd(5'd2, 32'h0000_0100, "R4 out-of-range high word");
        wr(5'd17, 32'd5);
        rd(5'd3, 32'h0, "R3 clear request ch5");
        // R5 word load
        wr(5'd3, 32'hA5A5_A5A5);
        rd(5'd3, 32'hA5A5_A5A5, "R5 request word load");
        @(negedge clk);
        chk(req_en[31:0] == 32'hA5A5_A5A5, "R5 req_en output", req_en[31:0], 32'hA5A5_A5A5);
        wr(5'd18, 32'd3);
        rd(5'd5, 32'h0000_0008, "R3 set error-interrupt enable ch3");
        // R6/R8 interrupt events
        ev((64'd1 << 7) | (64'd1 << 33), '0, '0);
        chk(irq == 1'b1, "R8 irq on interrupt flags", {31'b0, irq}, 32'h1);
        rd(5'd7, 32'h0000_0080, "R6 interrupt flag ch7");
        rd(5'd6, 32'h0000_0002, "R6 interrupt flag ch33");
        wr(5'd7, 32'h0000_0080);
        chk(irq == 1'b1, "R8 irq held by ch33", {31'b0, irq}, 32'h1);
        rd(5'd7, 32'h0, "R5 write-one-clear low");
        wr(5'd6, 32'hFFFF_FFFF);
        chk(irq == 1'b0, "R8 irq low when flags clear", {31'b0, irq}, 32'h0);
        rd(5'd6, 32'h0, "R5 write-ones clears high word");
        // R7 error capture, R8 masking
        detail = 8'h21; prio = 2'b01;
        ev('0, 64'd1 << 9, '0);
        chk(irq == 1'b0, "R8 error without enable", {31'b0, irq}, 32'h0);
        rd(5'd9, 32'h0000_0200, "R6 error flag ch9");
        rd(5'd1, 32'h8000_4921, "R7 first error captured");
        detail = 8'h80; prio = 2'b10;
        ev('0, 64'd1 << 3, '0);
        chk(irq == 1'b1, "R8 enabled error raises irq", {31'b0, irq}, 32'h1);
        rd(5'd1, 32'h8000_4921, "R7 later error does not overwrite");
        rd(5'd9, 32'h0000_0208, "R6 second error flag");
        wr(5'd21, 32'd3);
        chk(irq == 1'b0, "R8 irq after clearing error ch3", {31'b0, irq}, 32'h0);
        // R6 set wins over clear
        @(negedge clk);
        int_p = 64'h4; bus_wr = 1'b1; bus_addr = 5'd7; bus_wdata = 32'h4;
        @(negedge clk);
        int_p = '0; bus_wr = 1'b0;
        rd(5'd7, 32'h0000_0004, "R6 event beats same-cycle clear");
        wr(5'd20, 32'd2);
        rd(5'd7, 32'h0, "R3 clear interrupt command");
        // R7 release and lowest-channel capture
        wr(5'd1, 32'h8000_0000);
        rd(5'd1, 32'h0, "R7 release empties status");
        detail = 8'h05; prio = 2'b10;
        ev('0, (64'd1 << 50) | (64'd1 << 12), '0);
        rd(5'd1, 32'h8000_8C05, "R7 lowest channel captured");
        // R10 start / done
        wr(5'd22, 32'd4);
        rd(5'd13, 32'h0000_0010, "R10 set start ch4");
        ev('0, '0, 64'd1 << 4);
        rd(5'd13, 32'h0, "R10 done clears start");
        rd(5'd11, 32'h0000_0010, "R10 done flag set");
        wr(5'd23, 32'd4);
        rd(5'd11, 32'h0, "R10 clear done command");
        @(negedge clk);
        done_p = 64'd1 << 6; bus_wr = 1'b1; bus_addr = 5'd22; bus_wdata = 32'd6;
        @(negedge clk);
        done_p = '0; bus_wr = 1'b0;
        rd(5'd13, 32'h0000_0040, "R10 start set wins over done");
        rd(5'd11, 32'h0000_0040, "R10 done set alongside start");
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule